// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block is a small instruction cache placed between a processor fetch port and a slower external memory that delivers data in bursts. It is two-way set associative, with eight 32-bit words per line and one recency bit per set. A fetch that finds its word resident is answered on the next cycle. A fetch that misses reads the whole line from memory in one burst, stores it, and then answers. The burst also brings in the neighbouring instructions before they are needed.

Software can pin individual lines through a control port. Replacement never picks a pinned line, so time-critical code stays resident. Unpinned lines continue to be replaced automatically by recency. When both ways of a set are pinned, a miss to that set is served straight from memory and nothing is stored. The control port also provides unpin and a global invalidate. Data writes and coherency with other bus masters are outside this block.

Top module: `lockable_icache`

## Requirements
- R1: A fetch accepted (req_valid and req_ready high at a clock edge) whose line is resident raises resp_valid for one cycle at the next edge, with the cached word on resp_data, and issues no memory request.
- R2: A fetch that misses issues exactly one memory request. Its address is the line base: the word address with bits [2:0] cleared. Bits [5:3] select the set and bits [15:6] form the tag. The request holds steady until mem_req_ready. Eight beats follow, for offsets 0 to 7 in order. After the last beat the requested word is returned, and later fetches to any word of that line hit.
- R3: From the acceptance of a miss until its response, req_ready and ctl_ready stay low.
- R4: The fill target is the first invalid unpinned way, with way 0 tried first. If both ways are valid, the target is the least recently used unpinned way. Hits and fills both mark their way as most recently used.
- R5: A pinned line is never replaced by a fill, so it keeps returning its stored contents.
- R6: When both ways of the set are pinned, a missing fetch reads the line from memory and returns the requested word without storing it. A repeat of the same fetch misses again.
- R7: Control op 2'b01 (pin) on a resident address sets that line's pin with no memory traffic. On an absent address it first fills the line as in R4 and then pins it. No fetch response is produced.
- R8: Control op 2'b10 (unpin) clears the pin of the resident line holding the address, which then becomes replaceable. On an absent address it has no effect and causes no memory traffic.
- R9: Control op 2'b11 (invalidate) makes every line invalid and unpinned and resets the recency bits, so the next fetch to any address misses.
- R10: After reset resp_valid and mem_req_valid are low, req_ready and ctl_ready are high, and all lines are invalid.
- R11: While ctl_valid is high the control operation takes priority, and req_ready is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 16 | Fetch word address |
| req_ready | output | 1 | Fetch request can be accepted |
| resp_valid | output | 1 | One-cycle pulse: resp_data holds the fetched word |
| resp_data | output | 32 | Fetched instruction word |
| ctl_valid | input | 1 | Control operation present |
| ctl_op | input | 2 | 00 none, 01 pin, 10 unpin, 11 invalidate all |
| ctl_addr | input | 16 | Word address for pin and unpin |
| ctl_ready | output | 1 | Control operation can be accepted |
| mem_req_valid | output | 1 | Burst read request to external memory |
| mem_req_addr | output | 16 | Line-aligned word address of the burst |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | 32 | Burst beat data |

## Verification
The bench changes the memory contents between phases. A stale word therefore shows that a line was served from the cache, and a fresh word shows that it was refetched. This exposes a design that evicts a pinned line or evicts the most recently used way: such a design returns fresh data and makes an extra burst where the cache should hit. It also catches a design that allocates when both ways are pinned, because the repeated bypass fetch would then hit instead of bursting again. Other targets are the requested word sitting in the last beat of a burst, which a capture slip would return stale, and a pin on an absent line, which must burst once and then hold. Invalidate is checked for clearing the pin bits as well as the valid bits. A design that misses this would leave the set jammed in bypass.

// File: rtl/icache_pkg.sv
// Package: shared constants and encodings for the lockable instruction cache.
// Assumes a two-way organisation; the single recency bit per set relies on it.
package icache_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        CTL_NONE   = 2'b00,
        CTL_PIN    = 2'b01,
        CTL_UNPIN  = 2'b10,
        CTL_INVAL  = 2'b11
    } ctl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_REQ   = 2'b01,
        ST_BURST = 2'b10
    } fill_state_e;
endpackage

// File: rtl/icache_victim.sv
// Victim picker: chooses the way a fill will overwrite within one set.
// Pinned ways are excluded; an invalid way wins over recency; way 0 is tried
// first. Assumes two ways, so one recency bit names the least recent way.
module icache_victim
    import icache_pkg::*;
(
    input  logic [WAYS-1:0] way_valid,
    input  logic [WAYS-1:0] way_pinned,
    input  logic            lru_way,
    output logic            victim_way,
    output logic            no_victim
);
    // Priority selection of a replaceable way.
    always_comb begin
        no_victim  = &way_pinned;
        victim_way = 1'b0;
        if (way_pinned[0])       victim_way = 1'b1;
        else if (way_pinned[1])  victim_way = 1'b0;
        else if (!way_valid[0])  victim_way = 1'b0;
        else if (!way_valid[1])  victim_way = 1'b1;
        else                     victim_way = lru_way;
    end
endmodule

// File: rtl/icache_tag_store.sv
// Tag store: per-way tags, valid and pin bits, plus one recency bit per set.
// Provides a combinational lookup and separate update ports for fill, pin
// changes, recency touch and global invalidate. Assumes the caller never
// issues a fill and a pin change in the same cycle.
module icache_tag_store
    import icache_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 10,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_hit_way,
    output logic [WAYS-1:0]  lk_valid,
    output logic [WAYS-1:0]  lk_pinned,
    output logic             lk_lru,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_set,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_pin,
    input  logic             pin_we,
    input  logic [IDX_W-1:0] pin_set,
    input  logic             pin_way,
    input  logic             pin_val,
    input  logic             touch_we,
    input  logic [IDX_W-1:0] touch_set,
    input  logic             touch_way,
    input  logic             inval_all
);
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [SETS-1:0][WAYS-1:0] pin_q;
    logic [SETS-1:0]           lru_q;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic [WAYS-1:0]           way_match;

    // Per-way tag comparison for the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

    // Encode the matching way and expose the set's state for the victim picker.
    always_comb begin
        lk_hit     = |way_match;
        lk_hit_way = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) lk_hit_way = w[0];
        end
        lk_valid  = valid_q[lk_set];
        lk_pinned = pin_q[lk_set];
        lk_lru    = lru_q[lk_set];
    end

    // Valid, pin and recency state with reset and global invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n || inval_all) begin
            valid_q <= '0;
            pin_q   <= '0;
            lru_q   <= '0;
        end else begin
            if (fill_we) begin
                valid_q[fill_set][fill_way] <= 1'b1;
                pin_q[fill_set][fill_way]   <= fill_pin;
            end
            if (pin_we) pin_q[pin_set][pin_way] <= pin_val;
            if (touch_we) lru_q[touch_set] <= ~touch_way;
        end
    end

    // Tag array, written only when a line is allocated.
    always_ff @(posedge clk) begin
        if (fill_we) tag_q[fill_set][fill_way] <= fill_tag;
    end

    assert_no_pinned_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !pin_q[fill_set][fill_way]);

    assert_inval_clears_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |=> (valid_q == '0) && (pin_q == '0));
endmodule

// File: rtl/icache_data_store.sv
// Data store: line words for all sets and ways, addressed as {set, way, word}.
// One write port used by line fills, one combinational read port for hits.
module icache_data_store #(
    parameter int SETS       = 8,
    parameter int WAYS       = 2,
    parameter int LINE_WORDS = 8,
    parameter int WORD_W     = 32,
    localparam int DEPTH = SETS * WAYS * LINE_WORDS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] words_q [DEPTH];

    // Store one burst beat per cycle during a fill.
    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_idx] <= wr_data;
    end

    // Asynchronous read so a hit can be registered in the same cycle.
    assign rd_data = words_q[rd_idx];
endmodule

// File: rtl/lockable_icache.sv
// Top of the lockable two-way instruction cache.
// Accepts one fetch or one control operation per idle cycle (control first).
// Hits answer on the next cycle; misses and pin-misses run a single line
// burst, during which both request ports are stalled. Assumes memory returns
// exactly LINE_WORDS beats, lowest offset first, after accepting a request.
module lockable_icache
    import icache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SETS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    input  logic              ctl_valid,
    input  logic [1:0]        ctl_op,
    input  logic [ADDR_W-1:0] ctl_addr,
    output logic              ctl_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(LINE_WORDS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int DS_AW = $clog2(SETS * WAYS * LINE_WORDS);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

    fill_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              way_q;
    logic              alloc_q;
    logic              pinop_q;
    logic [OFF_W-1:0]  beat_q;
    logic [WORD_W-1:0] word_q;
    logic              resp_valid_q;
    logic [WORD_W-1:0] resp_data_q;

    logic              idle;
    logic              ctl_fire;
    logic              fetch_fire;
    logic              start_fill;
    logic              fill_done;
    ctl_op_e           op;
    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_set;
    logic [TAG_W-1:0]  lk_tag;
    logic [OFF_W-1:0]  lk_off;
    logic [IDX_W-1:0]  q_set;
    logic [TAG_W-1:0]  q_tag;
    logic [OFF_W-1:0]  q_off;

    logic              lk_hit;
    logic              lk_hit_way;
    logic [WAYS-1:0]   lk_valid;
    logic [WAYS-1:0]   lk_pinned;
    logic              lk_lru;
    logic              vic_way;
    logic              vic_none;

    logic              fill_we;
    logic              pin_we;
    logic              pin_val;
    logic              touch_we;
    logic [IDX_W-1:0]  touch_set;
    logic              touch_way;
    logic              inval_all;
    logic              ds_we;
    logic [DS_AW-1:0]  ds_wr_idx;
    logic [DS_AW-1:0]  ds_rd_idx;
    logic [WORD_W-1:0] ds_rd_data;

    // Handshakes and address field split for lookup and the pending fill.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        ctl_ready  = idle;
        req_ready  = idle && !ctl_valid;
        ctl_fire   = ctl_valid && idle;
        fetch_fire = req_valid && req_ready;
        op         = ctl_op_e'(ctl_op);
        lk_addr    = ctl_valid ? ctl_addr : req_addr;
        lk_off     = lk_addr[OFF_W-1:0];
        lk_set     = lk_addr[OFF_W +: IDX_W];
        lk_tag     = lk_addr[ADDR_W-1 -: TAG_W];
        q_off      = addr_q[OFF_W-1:0];
        q_set      = addr_q[OFF_W +: IDX_W];
        q_tag      = addr_q[ADDR_W-1 -: TAG_W];
    end

    icache_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (lk_set),
        .lk_tag     (lk_tag),
        .lk_hit     (lk_hit),
        .lk_hit_way (lk_hit_way),
        .lk_valid   (lk_valid),
        .lk_pinned  (lk_pinned),
        .lk_lru     (lk_lru),
        .fill_we    (fill_we),
        .fill_set   (q_set),
        .fill_way   (way_q),
        .fill_tag   (q_tag),
        .fill_pin   (pinop_q),
        .pin_we     (pin_we),
        .pin_set    (lk_set),
        .pin_way    (lk_hit_way),
        .pin_val    (pin_val),
        .touch_we   (touch_we),
        .touch_set  (touch_set),
        .touch_way  (touch_way),
        .inval_all  (inval_all)
    );

    icache_victim u_victim (
        .way_valid  (lk_valid),
        .way_pinned (lk_pinned),
        .lru_way    (lk_lru),
        .victim_way (vic_way),
        .no_victim  (vic_none)
    );

    icache_data_store #(
        .SETS       (SETS),
        .WAYS       (WAYS),
        .LINE_WORDS (LINE_WORDS),
        .WORD_W     (WORD_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (ds_we),
        .wr_idx  (ds_wr_idx),
        .wr_data (mem_rdata),
        .rd_idx  (ds_rd_idx),
        .rd_data (ds_rd_data)
    );

    // Decode idle-cycle actions and fill completion into store update strobes.
    always_comb begin
        fill_done  = (state_q == ST_BURST) && mem_rvalid && (beat_q == LAST_BEAT);
        start_fill = (fetch_fire && !lk_hit)
                   || (ctl_fire && (op == CTL_PIN) && !lk_hit && !vic_none);
        pin_we     = ctl_fire && lk_hit && ((op == CTL_PIN) || (op == CTL_UNPIN));
        pin_val    = (op == CTL_PIN);
        inval_all  = ctl_fire && (op == CTL_INVAL);
        fill_we    = fill_done && alloc_q;
        if (fill_we) begin
            touch_we  = 1'b1;
            touch_set = q_set;
            touch_way = way_q;
        end else begin
            touch_we  = fetch_fire && lk_hit;
            touch_set = lk_set;
            touch_way = lk_hit_way;
        end
        ds_we     = (state_q == ST_BURST) && mem_rvalid && alloc_q;
        ds_wr_idx = {q_set, way_q, beat_q};
        ds_rd_idx = {lk_set, lk_hit_way, lk_off};
    end

    // Fill sequencer and registered fetch response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            addr_q       <= '0;
            way_q        <= 1'b0;
            alloc_q      <= 1'b0;
            pinop_q      <= 1'b0;
            beat_q       <= '0;
            word_q       <= '0;
            resp_valid_q <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (fetch_fire && lk_hit) begin
                        resp_valid_q <= 1'b1;
                        resp_data_q  <= ds_rd_data;
                    end
                    if (start_fill) begin
                        addr_q  <= lk_addr;
                        way_q   <= vic_way;
                        alloc_q <= !vic_none;
                        pinop_q <= ctl_fire;
                        state_q <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        beat_q  <= '0;
                        state_q <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (mem_rvalid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == q_off) word_q <= mem_rdata;
                        if (beat_q == LAST_BEAT) begin
                            state_q <= ST_IDLE;
                            if (!pinop_q) begin
                                resp_valid_q <= 1'b1;
                                resp_data_q  <= (q_off == LAST_BEAT) ? mem_rdata : word_q;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid    = resp_valid_q;
    assign resp_data     = resp_data_q;
    assign mem_req_valid = (state_q == ST_REQ);
    assign mem_req_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    assert_hit_next_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_fire && lk_hit) |=> resp_valid);

    assert_miss_issues_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_fire && !lk_hit) |=> mem_req_valid && (mem_req_addr[OFF_W-1:0] == '0));

    assert_request_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

    assert_stalled_in_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !req_ready && !ctl_ready);
endmodule

// File: tb/lockable_icache_test.sv
`timescale 1ns/1ps
module lockable_icache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic        ctl_valid = 1'b0;
    logic [1:0]  ctl_op = 2'b00;
    logic [15:0] ctl_addr = '0;
    logic        ctl_ready;
    logic        mem_req_valid;
    logic [15:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int nreq   = 0;
    int gen    = 1;
    bit finished = 0;

    bit       m_valid [8][2];
    bit [9:0] m_tag   [8][2];
    bit       m_pin   [8][2];
    int       m_gen   [8][2];
    bit       m_lru   [8];

    always #2 clk = ~clk;

    lockable_icache uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_addr(ctl_addr), .ctl_ready(ctl_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memval(input logic [15:0] a, input int g);
        logic [7:0] gb;
        gb = g[7:0];
        return {gb, 8'hC3, a};
    endfunction

    function automatic logic [15:0] mk(input int t, input int s, input int o);
        logic [9:0] tb;
        logic [2:0] sb;
        logic [2:0] ob;
        tb = t[9:0];
        sb = s[2:0];
        ob = o[2:0];
        return {tb, sb, ob};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 8; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) begin
                m_valid[s][w] = 0;
                m_pin[s][w]   = 0;
            end
        end
    endtask

    // Expected victim by requirement R4; returns -1 when both ways are pinned.
    function automatic int pick_victim(input int s);
        if (m_pin[s][0] && m_pin[s][1]) return -1;
        if (m_pin[s][0]) return 1;
        if (m_pin[s][1]) return 0;
        if (!m_valid[s][0]) return 0;
        if (!m_valid[s][1]) return 1;
        return int'(m_lru[s]);
    endfunction

    function automatic int find_way(input logic [15:0] a);
        int s;
        s = int'(a[5:3]);
        for (int w = 0; w < 2; w++)
            if (m_valid[s][w] && m_tag[s][w] == a[15:6]) return w;
        return -1;
    endfunction

    // Memory responder: accepts a request, then returns eight beats with random gaps.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                logic [15:0] base;
                base = mem_req_addr;
                nreq++;
                check(base[2:0] == 3'd0, "R2", "burst address aligned", {16'h0, base}, {16'h0, base & 16'hFFF8});
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int b = 0; b < 8; b++) begin
                    if ($urandom % 4 == 0) begin
                        mem_rvalid = 1'b0;
                        @(negedge clk);
                    end
                    mem_rvalid = 1'b1;
                    mem_rdata  = memval(base + 16'(b), gen);
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    task automatic do_fetch(input logic [15:0] a, input string lbl);
        int s, w, v, n0, cyc;
        bit stall_bad;
        logic [31:0] exp;
        string tag;
        s = int'(a[5:3]);
        w = find_way(a);
        v = (w < 0) ? pick_victim(s) : 0;
        if (w >= 0) begin
            exp = memval(a, m_gen[s][w]);
            tag = "R1";
        end else begin
            exp = memval(a, gen);
            tag = (v < 0) ? "R6" : "R2";
        end
        if (lbl != "") tag = lbl;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        cyc = 0;
        while (!req_ready && cyc < 100) begin @(negedge clk); cyc++; end
        n0 = nreq;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        stall_bad = 0;
        while (!resp_valid && cyc < 200) begin
            if (req_ready || ctl_ready) stall_bad = 1;
            @(negedge clk);
            cyc++;
        end
        check(resp_valid == 1'b1, tag, "response arrived", {31'h0, resp_valid}, 32'h1);
        check(resp_data == exp, tag, "fetched word", resp_data, exp);
        check(nreq - n0 == ((w >= 0) ? 0 : 1), tag, "memory requests", nreq - n0, (w >= 0) ? 0 : 1);
        if (w >= 0) begin
            check(cyc == 1, "R1", "hit latency", cyc, 1);
            m_lru[s] = ~w[0];
        end else begin
            check(!stall_bad, "R3", "ports stalled during burst", {31'h0, stall_bad}, 0);
            if (v >= 0) begin
                m_valid[s][v] = 1;
                m_tag[s][v]   = a[15:6];
                m_pin[s][v]   = 0;
                m_gen[s][v]   = gen;
                m_lru[s]      = ~v[0];
            end
        end
    endtask

    task automatic do_ctl(input logic [1:0] op, input logic [15:0] a, input string lbl);
        int s, w, v, n0, cyc, expn;
        s = int'(a[5:3]);
        w = find_way(a);
        v = pick_victim(s);
        expn = (op == 2'b01 && w < 0 && v >= 0) ? 1 : 0;
        @(negedge clk);
        ctl_valid = 1'b1;
        ctl_op    = op;
        ctl_addr  = a;
        req_valid = 1'b1;
        req_addr  = a ^ 16'h0040;
        #0.1;
        check(req_ready == 1'b0, "R11", "fetch held off by control", {31'h0, req_ready}, 0);
        n0 = nreq;
        @(negedge clk);
        ctl_valid = 1'b0;
        req_valid = 1'b0;
        cyc = 0;
        while (!ctl_ready && cyc < 200) begin @(negedge clk); cyc++; end
        check(nreq - n0 == expn, lbl, "control memory traffic", nreq - n0, expn);
        check(resp_valid == 1'b0, lbl, "no response to control", {31'h0, resp_valid}, 0);
        if (op == 2'b11) model_clear();
        else if (op == 2'b10) begin
            if (w >= 0) m_pin[s][w] = 0;
        end else if (op == 2'b01) begin
            if (w >= 0) m_pin[s][w] = 1;
            else if (v >= 0) begin
                m_valid[s][v] = 1;
                m_tag[s][v]   = a[15:6];
                m_pin[s][v]   = 1;
                m_gen[s][v]   = gen;
                m_lru[s]      = ~v[0];
            end
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 0, "R10", "resp_valid after reset", {31'h0, resp_valid}, 0);
        check(mem_req_valid == 0, "R10", "mem_req_valid after reset", {31'h0, mem_req_valid}, 0);
        check(req_ready && ctl_ready, "R10", "ready after reset", {30'h0, req_ready, ctl_ready}, 3);

        // Fill then hit within one line, including the last word of the line.
        do_fetch(mk(1, 2, 7), "R2");
        do_fetch(mk(1, 2, 3), "R1");
        do_fetch(mk(1, 2, 0), "R1");

        // Recency: stale data reveals which way survived.
        gen++;
        do_fetch(mk(2, 2, 1), "R4");
        do_fetch(mk(1, 2, 5), "R4");
        do_fetch(mk(3, 2, 0), "R4");
        do_fetch(mk(1, 2, 6), "R4");
        do_fetch(mk(2, 2, 1), "R4");

        // Pin an absent line, then stress the set with misses.
        gen++;
        do_ctl(2'b01, mk(5, 2, 0), "R7");
        gen++;
        do_fetch(mk(6, 2, 0), "R5");
        do_fetch(mk(7, 2, 0), "R5");
        do_fetch(mk(5, 2, 4), "R5");
        do_fetch(mk(8, 2, 0), "R5");
        do_fetch(mk(5, 2, 7), "R5");

        // Pin the resident other way: no traffic; set now fully pinned.
        do_ctl(2'b01, mk(8, 2, 2), "R7");
        gen++;
        do_fetch(mk(9, 2, 3), "R6");
        do_fetch(mk(9, 2, 3), "R6");
        do_fetch(mk(8, 2, 5), "R6");

        // Unpin: absent address has no effect; resident one becomes replaceable.
        do_ctl(2'b10, mk(9, 2, 0), "R8");
        do_fetch(mk(9, 2, 1), "R8");
        do_ctl(2'b10, mk(8, 2, 0), "R8");
        do_fetch(mk(9, 2, 1), "R8");
        do_fetch(mk(5, 2, 2), "R8");
        do_fetch(mk(8, 2, 0), "R8");

        // Invalidate clears contents and pins.
        gen++;
        do_ctl(2'b11, 16'h0000, "R9");
        do_fetch(mk(5, 2, 2), "R9");
        do_fetch(mk(10, 2, 0), "R9");
        do_fetch(mk(11, 2, 0), "R9");
        do_fetch(mk(1, 2, 7), "R2");

        // Constrained random mix checked against the bench model.
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [15:0] a;
            r = int'($urandom % 100);
            a = mk(int'($urandom % 6), int'($urandom % 4), int'($urandom % 8));
            if (r < 70)      do_fetch(a, "");
            else if (r < 80) do_ctl(2'b01, a, "R7");
            else if (r < 90) do_ctl(2'b10, a, "R8");
            else if (r < 92) do_ctl(2'b11, a, "R9");
            else             gen++;
        end

        finished = 1;
        finish_run();
    end
endmodule